// File: doc/BRIEF.md
# Alternating Real/Noise State Register

This block takes the place of the single round-state register in an iterative 128-bit cipher datapath. It runs on a clock twice as fast as the round logic. On alternate fast cycles it writes either the true state word or a pseudo-random word into one of two internal registers. Because real and random writes interleave, the switching activity of the storage no longer follows the data alone, and the datapath does not have to be duplicated to get this effect.

A single multiplexer, steered by a phase bit, feeds both registers. In the real phase it passes the incoming word. In the random phase it passes the current word of an internal 128-bit maximal-length shift-register generator. The phase bit picks which of the two registers is written. The round logic reads the real register, which changes only when a word is accepted. The random register is brought out for test.

The input is a valid/ready stream. `in_ready` is high only in the real phase, so the block applies back-pressure during every random phase. A word transfers on a fast edge where both `in_valid` and `in_ready` are high. A producer that holds `in_valid` high across a random phase must keep `in_data` until the next real phase. The output side takes no back-pressure: `out_data` is a held state value, and `out_valid` marks the one fast cycle right after a transfer.

Top module: `dr_mask_reg`

## Requirements
- R1: While reset is held and in the first cycle after it, `phase` is 0, `in_ready` is 1, `out_valid` is 0, and `out_data` and `rnd_out` are all zeros.
- R2: `phase` inverts on every fast clock edge after reset. `in_ready` equals the inverse of `phase`, so it is 1 in the real phase (`phase`=0) and 0 in the random phase (`phase`=1).
- R3: When `in_valid` and `in_ready` are both 1 at an edge, `out_data` shows the `in_data` word from that cycle after the edge.
- R4: On any edge without a transfer, `out_data` keeps its value. This covers every random-phase edge, whatever `in_valid` and `in_data` are doing.
- R5: The generator starts from a nonzero seed parameter and advances once on every random-phase edge, whether or not input arrives. One advance shifts the 128-bit word left by one bit and enters, as the new bit 0, the XOR of bits 127, 28, 27 and 26. This is the polynomial x^128+x^29+x^28+x^27+1. The generator word is never zero.
- R6: On the random-phase edge that directly follows a transfer, `rnd_out` loads the generator word from before that edge's advance. On every other edge, `rnd_out` holds its value.
- R7: `out_valid` is 1 for exactly the one cycle after a transfer. That cycle is always a random-phase cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, twice the round rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block accepts a word (real phase) |
| in_data | input | 128 | Real state word |
| out_valid | output | 1 | One-cycle pulse after a transfer |
| out_data | output | 128 | Most recently accepted real word |
| phase | output | 1 | 0 in the real phase, 1 in the random phase |
| rnd_out | output | 128 | Random register, for test |

## Verification
Two events share the same random-phase edge: the generator advances, and the random register captures a word. The random register must get the word from before the advance. The bench sets this up by transferring words in many different real phases, with gaps between them, so the capture edges fall at scattered points in the generator sequence. Its behavioural model then compares `rnd_out` with the pre-advance word on every cycle. In a second case, a transfer and a new offer overlap: `in_valid` stays high and `in_data` changes during the random phase. The bench judges this by whether `out_data` keeps the real-phase word.

// File: rtl/dr_mask_pkg.sv
package dr_mask_pkg;
  localparam int unsigned STATE_W = 128;
  // Feedback bit positions for x^128 + x^29 + x^28 + x^27 + 1 (shift-left form)
  localparam logic [STATE_W-1:0] FB_TAPS =
    (128'd1 << 127) | (128'd1 << 28) | (128'd1 << 27) | (128'd1 << 26);
  localparam logic [STATE_W-1:0] FB_SEED = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

  typedef enum logic {PH_REAL = 1'b0, PH_RAND = 1'b1} phase_e;
endpackage

// File: rtl/dr_phase_ctl.sv
module dr_phase_ctl
  import dr_mask_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e ph
);
  always_ff @(posedge clk) begin
    if (!rst_n) ph <= PH_REAL;
    else        ph <= (ph == PH_REAL) ? PH_RAND : PH_REAL;
  end
endmodule

// File: rtl/dr_lfsr.sv
module dr_lfsr #(
  parameter int unsigned   W    = 128,
  parameter logic [W-1:0]  TAPS = '1,
  parameter logic [W-1:0]  SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] word
);
  logic fb;
  assign fb = ^(word & TAPS);

  always_ff @(posedge clk) begin
    if (!rst_n)    word <= SEED;
    else if (step) word <= {word[W-2:0], fb};
  end
endmodule

// File: rtl/dr_store.sv
module dr_store
  import dr_mask_pkg::*;
#(
  parameter int unsigned W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  phase_e       ph,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic [W-1:0] noise,
  output logic         pend,
  output logic [W-1:0] real_q,
  output logic [W-1:0] rand_q
);
  logic [W-1:0] mux_w;
  logic         ld_real, ld_rand;

  // One shared selector feeds both storage registers
  assign mux_w   = (ph == PH_RAND) ? noise : in_data;
  assign ld_real = (ph == PH_REAL) && in_valid;
  assign ld_rand = (ph == PH_RAND) && pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      real_q <= '0;
      rand_q <= '0;
      pend   <= 1'b0;
    end else begin
      if (ld_real) real_q <= mux_w;
      if (ld_rand) rand_q <= mux_w;
      pend <= ld_real;
    end
  end
endmodule

// File: rtl/dr_mask_reg.sv
module dr_mask_reg
  import dr_mask_pkg::*;
#(
  parameter int unsigned         WIDTH = STATE_W,
  parameter logic [WIDTH-1:0]    TAPS  = FB_TAPS,
  parameter logic [WIDTH-1:0]    SEED  = FB_SEED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic             phase,
  output logic [WIDTH-1:0] rnd_out
);
  phase_e           ph;
  logic [WIDTH-1:0] lfsr_q;

  dr_phase_ctl u_ph (
    .clk  (clk),
    .rst_n(rst_n),
    .ph   (ph)
  );

  dr_lfsr #(.W(WIDTH), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk  (clk),
    .rst_n(rst_n),
    .step (ph == PH_RAND),
    .word (lfsr_q)
  );

  dr_store #(.W(WIDTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .ph      (ph),
    .in_valid(in_valid),
    .in_data (in_data),
    .noise   (lfsr_q),
    .pend    (out_valid),
    .real_q  (out_data),
    .rand_q  (rnd_out)
  );

  assign phase    = (ph == PH_RAND);
  assign in_ready = (ph == PH_REAL);
endmodule

// File: rtl/dr_mask_reg_chk.sv
module dr_mask_reg_chk #(
  parameter int unsigned W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_data,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         phase,
  input logic [W-1:0] rnd_out,
  input logic [W-1:0] lfsr_q
);
  // R2
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase != $past(phase));
  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_data == $past(in_data));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(out_data));
  // R5
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
  // R5
  lfsr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase |=> $stable(lfsr_q));
  // R6
  rnd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase && out_valid) |=> rnd_out == $past(lfsr_q));
  // R6
  rnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase && out_valid) |=> $stable(rnd_out));
  // R7
  valid_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> phase);
  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
endmodule

bind dr_mask_reg dr_mask_reg_chk #(.W(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_data (out_data),
  .phase    (phase),
  .rnd_out  (rnd_out),
  .lfsr_q   (lfsr_q)
);

// File: tb/dr_mask_reg_tb.sv
module dr_mask_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [127:0] SEED = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] in_data = '0;
  logic         in_ready, out_valid, phase;
  logic [127:0] out_data, rnd_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  bit           m_phase, m_valid;
  logic [127:0] m_data, m_rnd, m_gen;
  int unsigned  rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  dr_mask_reg u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .phase(phase), .rnd_out(rnd_out)
  );

  function automatic logic [127:0] gen_next(logic [127:0] s);
    logic b;
    b = s[127] ^ s[28] ^ s[27] ^ s[26];
    return {s[126:0], b};
  endfunction

  function automatic int unsigned xs(int unsigned v);
    v = v ^ (v << 13);
    v = v ^ (v >> 17);
    v = v ^ (v << 5);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(phase == m_phase,     "R2 phase",     128'(phase), 128'(m_phase));
    chk(in_ready == !m_phase, "R2 in_ready",  128'(in_ready), 128'(!m_phase));
    chk(out_data == m_data,   "R3/R4 out_data", out_data, m_data);
    chk(out_valid == m_valid, "R7 out_valid", 128'(out_valid), 128'(m_valid));
    chk(rnd_out == m_rnd,     "R5/R6 rnd_out", rnd_out, m_rnd);
  endtask

  task automatic model_edge();
    if (!m_phase) begin
      m_valid = in_valid;
      if (in_valid) m_data = in_data;
    end else begin
      if (m_valid) m_rnd = m_gen;
      m_gen   = gen_next(m_gen);
      m_valid = 0;
    end
    m_phase = !m_phase;
  endtask

  // mode: 0 valid always, 1 valid only in random phase, 2 random pattern, 3 sparse
  task automatic run(input int mode, input int n);
    for (int i = 0; i < n; i++) begin
      rng = xs(rng);
      case (mode)
        0: in_valid = 1'b1;
        1: in_valid = m_phase;
        2: in_valid = rng[3];
        default: in_valid = (rng[2:0] == 3'd0);
      endcase
      for (int k = 0; k < 4; k++) begin
        rng = xs(rng);
        in_data[k*32 +: 32] = rng;
      end
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
    end
  endtask

  initial begin
    m_phase = 0; m_valid = 0; m_data = '0; m_rnd = '0; m_gen = SEED;
    repeat (3) @(negedge clk);
    // R1 under reset
    compare_all();
    rst_n = 1'b1;
    // R1 first cycle out of reset
    compare_all();

    // R3: first word, then random-phase noise on the input is ignored (R4)
    in_valid = 1'b1; in_data = {4{32'hA5A5_0001}};
    @(posedge clk); model_edge(); @(negedge clk); compare_all();
    chk(out_data == {4{32'hA5A5_0001}}, "R3 first capture", out_data, {4{32'hA5A5_0001}});
    chk(out_valid && phase, "R7 pulse in random phase", 128'({out_valid, phase}), 128'd3);
    in_data = {4{32'hDEAD_BEEF}};
    @(posedge clk); model_edge(); @(negedge clk); compare_all();
    chk(out_data == {4{32'hA5A5_0001}}, "R4 random-phase input ignored", out_data, {4{32'hA5A5_0001}});
    // R5/R6: first random capture is the seed word
    chk(rnd_out == SEED, "R6 first random load is seed", rnd_out, SEED);

    run(0, 60);
    run(1, 40);
    // R6: without transfers rnd_out must stay
    begin
      logic [127:0] held;
      held = rnd_out;
      run(1, 20);
      chk(rnd_out == held, "R6 hold without transfer", rnd_out, held);
    end
    run(2, 200);
    run(3, 200);
    // R5: generator word never zero
    chk(rnd_out != '0, "R5 nonzero noise", rnd_out, m_rnd);

    // R1 again: reset mid-run
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    m_phase = 0; m_valid = 0; m_data = '0; m_rnd = '0; m_gen = SEED;
    @(negedge clk);
    compare_all();
    rst_n = 1'b1;
    run(2, 100);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule